// File: doc/BRIEF.md
# Sleep Mode Entry Controller

This block governs the low-power sleep state of a synchronous memory. A sleep request pin arrives without any timing relation to the clock. The block samples it through a chain of synchronizer flops. It then steps through a fixed entry sequence, holds the sleep state while the request stays high, and steps through a fixed exit sequence. The last phase is a recovery window, during which the chip enables must stay inactive. Stored contents are not touched at any point, so the memory array keeps its data through sleep.

Access attempts reach the block on one request input. An attempt is forwarded to the array only when the controller is fully awake and the synchronized request is low. An attempt made in any other cycle is dropped. This includes an access still pending in the cycle the request is first seen. A dropped attempt also sets a sticky violation flag, and only reset clears that flag.

The controller is one state machine with five states:
- `ST_AWAKE`: normal operation.
- `ST_ENTER`: entry countdown.
- `ST_ASLEEP`: the sleep state.
- `ST_EXIT`: exit countdown.
- `ST_RECOVER`: recovery window.

Its transitions are:
- AWAKE to ENTER, on the synchronized request.
- ENTER to ASLEEP, when the entry count ends.
- ASLEEP to EXIT, when the synchronized request is low.
- EXIT to RECOVER, when the exit count ends.
- RECOVER to AWAKE, when the recovery count ends.

Top module: `sleep_ctrl`

## Requirements
- R1: After reset, `asleep`, `acc_blocked`, `acc_go` and `proto_viol` are all 0.
- R2: `sleep_req_a` passes through two synchronizer flops. Driven high before clock edge k, it first makes `acc_blocked` read 1 after edge k+1.
- R3: The state then spends ENTRY_CYC (default 2) cycles in ENTER. `asleep` reads 1 after edge k+4.
- R4: Once the synchronized request is seen low in ASLEEP, the state spends EXIT_CYC (default 2) cycles in EXIT. `asleep` reads 0 in the first of those cycles.
- R5: After EXIT, the state spends RECOV_CYC (default 2) cycles in RECOVER with `acc_blocked` held at 1. It then returns to AWAKE, and `acc_blocked` reads 0 when the request is low.
- R6: While awake with the synchronized request low, `acc_go` equals `acc_req` in the same cycle.
- R7: In any cycle where `acc_blocked` is 1, `acc_go` is 0. This includes the cycle in which the synchronized request is first seen, so a pending access is discarded.
- R8: An `acc_req` in a blocked cycle sets `proto_viol` at the next edge. The flag stays 1 until reset.
- R9: `asleep` is 1 only in ASLEEP. `acc_blocked` is 1 in every state other than AWAKE.
- R10: A request that falls during ENTER does not abort entry. The state reaches ASLEEP for at least one cycle and then takes the full exit and recovery path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req_a | input | 1 | Sleep request, asynchronous to clk |
| acc_req | input | 1 | Access attempt (chip enables active) |
| acc_go | output | 1 | Access forwarded to the array |
| acc_blocked | output | 1 | Accesses currently refused |
| asleep | output | 1 | Controller in the sleep state |
| proto_viol | output | 1 | Sticky flag: access attempted while blocked |

## Verification
The in-RTL assertions check several rules on every cycle:
- a forwarded access never coincides with a blocked cycle;
- `asleep` always implies the busy condition;
- the violation flag never clears without reset;
- ASLEEP is only entered from ENTER, and AWAKE is only re-entered from RECOVER.

Some behaviours only the bench scenarios can show:
- the exact cycle counts of synchronization, entry, exit and recovery;
- the discard of an access pending in the cycle the request is first seen;
- completion of entry after a request that was withdrawn early.

// File: rtl/sleep_pkg.sv
package sleep_pkg;

    typedef enum logic [2:0] {
        ST_AWAKE   = 3'd0,
        ST_ENTER   = 3'd1,
        ST_ASLEEP  = 3'd2,
        ST_EXIT    = 3'd3,
        ST_RECOVER = 3'd4
    } pwr_state_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sleep_sync.sv
module sleep_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
    import sleep_pkg::*;
#(
    parameter int ENTRY_CYC = 2,
    parameter int EXIT_CYC  = 2,
    parameter int RECOV_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_s,
    output logic asleep,
    output logic busy
);
    localparam int MAXC  = max3(ENTRY_CYC, EXIT_CYC, RECOV_CYC);
    localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CNT_W-1:0] ENTRY_LD = CNT_W'(ENTRY_CYC - 1);
    localparam logic [CNT_W-1:0] EXIT_LD  = CNT_W'(EXIT_CYC - 1);
    localparam logic [CNT_W-1:0] RECOV_LD = CNT_W'(RECOV_CYC - 1);

    pwr_state_t       state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             cnt_done;

    assign cnt_done = (cnt == '0);

    // next-state and counter logic
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_AWAKE: begin
                if (req_s) begin
                    state_nx = ST_ENTER;
                    cnt_nx   = ENTRY_LD;
                end
            end
            ST_ENTER: begin
                if (cnt_done) state_nx = ST_ASLEEP;
                else          cnt_nx   = cnt - 1'b1;
            end
            ST_ASLEEP: begin
                if (!req_s) begin
                    state_nx = ST_EXIT;
                    cnt_nx   = EXIT_LD;
                end
            end
            ST_EXIT: begin
                if (cnt_done) begin
                    state_nx = ST_RECOVER;
                    cnt_nx   = RECOV_LD;
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
            ST_RECOVER: begin
                if (cnt_done) state_nx = ST_AWAKE;
                else          cnt_nx   = cnt - 1'b1;
            end
            default: begin
                state_nx = ST_AWAKE;
                cnt_nx   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_AWAKE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // outputs
    always_comb begin
        asleep = 1'b0;
        busy   = 1'b1;
        unique case (state)
            ST_AWAKE:   busy   = 1'b0;
            ST_ASLEEP:  asleep = 1'b1;
            ST_ENTER, ST_EXIT, ST_RECOVER: busy = 1'b1;
            default:    busy   = 1'b1;
        endcase
    end

    // R9
    sleep_implies_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> busy);

    // R3
    asleep_from_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ASLEEP && $past(state) != ST_ASLEEP && $past(rst_n)) |-> $past(state) == ST_ENTER);

    // R5
    awake_from_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AWAKE && $past(state) != ST_AWAKE && $past(rst_n)) |-> $past(state) == ST_RECOVER);

    // R2
    entry_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ENTER && $past(state) == ST_AWAKE && $past(rst_n)) |-> $past(req_s));
endmodule

// File: rtl/sleep_viol.sv
module sleep_viol (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_req,
    input  logic blocked,
    output logic viol
);
    always_ff @(posedge clk) begin
        if (!rst_n)                  viol <= 1'b0;
        else if (acc_req && blocked) viol <= 1'b1;
    end

    // R8
    viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> viol);
endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl #(
    parameter int SYNC_STAGES = 2,
    parameter int ENTRY_CYC   = 2,
    parameter int EXIT_CYC    = 2,
    parameter int RECOV_CYC   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req_a,
    input  logic acc_req,
    output logic acc_go,
    output logic acc_blocked,
    output logic asleep,
    output logic proto_viol
);
    logic req_s;
    logic busy;

    sleep_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (sleep_req_a),
        .q_sync  (req_s)
    );

    sleep_fsm #(
        .ENTRY_CYC (ENTRY_CYC),
        .EXIT_CYC  (EXIT_CYC),
        .RECOV_CYC (RECOV_CYC)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_s  (req_s),
        .asleep (asleep),
        .busy   (busy)
    );

    assign acc_blocked = busy | req_s;
    assign acc_go      = acc_req & ~acc_blocked;

    sleep_viol u_viol (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_req (acc_req),
        .blocked (acc_blocked),
        .viol    (proto_viol)
    );

    // R7
    no_go_when_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_blocked |-> !acc_go);

    // R6
    go_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_s && acc_req) |-> acc_go);
endmodule

// File: tb/tb_sleep_ctrl.sv
module tb_sleep_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req_a = 1'b0;
    logic acc_req = 1'b0;
    logic acc_go, acc_blocked, asleep, proto_viol;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        bit    sl;
        bit    bl;
        bit    go;
        bit    vi;
        string tag;
    } exp_t;

    exp_t q[$];

    always #2 clk = ~clk;

    sleep_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_req_a (sleep_req_a),
        .acc_req     (acc_req),
        .acc_go      (acc_go),
        .acc_blocked (acc_blocked),
        .asleep      (asleep),
        .proto_viol  (proto_viol)
    );

    // driver: set inputs for one cycle and push the expected outputs
    task automatic step(input bit req, input bit acc, input bit e_sl, input bit e_bl,
                        input bit e_go, input bit e_vi, input string tag);
        exp_t e;
        @(negedge clk);
        sleep_req_a = req;
        acc_req     = acc;
        e.sl = e_sl; e.bl = e_bl; e.go = e_go; e.vi = e_vi; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sleep_req_a = 1'b0;
        acc_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // monitor: sample before the next rising edge and compare
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_tests++;
                if (asleep !== e.sl || acc_blocked !== e.bl || acc_go !== e.go || proto_viol !== e.vi) begin
                    n_fail++;
                    $display("FAIL %s: got sl=%b bl=%b go=%b vi=%b exp sl=%b bl=%b go=%b vi=%b",
                             e.tag, asleep, acc_blocked, acc_go, proto_viol, e.sl, e.bl, e.go, e.vi);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        step(0, 0, 0, 0, 0, 0, "R1");
        // R6 accesses pass while awake
        step(0, 1, 0, 0, 1, 0, "R6");
        step(0, 0, 0, 0, 0, 0, "R6");
        step(0, 1, 0, 0, 1, 0, "R6");

        // sleep entry: R2 synchronizer, R3 entry count
        step(1, 0, 0, 0, 0, 0, "R2");
        step(1, 0, 0, 0, 0, 0, "R2");
        step(1, 0, 0, 1, 0, 0, "R2");
        step(1, 0, 0, 1, 0, 0, "R3");
        step(1, 0, 0, 1, 0, 0, "R3");
        step(1, 0, 1, 1, 0, 0, "R3");
        step(1, 0, 1, 1, 0, 0, "R9");
        // exit: R4, recovery: R5
        step(0, 0, 1, 1, 0, 0, "R4");
        step(0, 0, 1, 1, 0, 0, "R4");
        step(0, 0, 1, 1, 0, 0, "R4");
        step(0, 0, 0, 1, 0, 0, "R4");
        step(0, 0, 0, 1, 0, 0, "R9");
        step(0, 0, 0, 1, 0, 0, "R5");
        step(0, 0, 0, 1, 0, 0, "R5");
        step(0, 0, 0, 0, 0, 0, "R5");
        step(0, 1, 0, 0, 1, 0, "R6");
        step(0, 0, 0, 0, 0, 0, "R6");

        // pending access discarded at request detection: R7, R8
        step(1, 0, 0, 0, 0, 0, "R7");
        step(1, 0, 0, 0, 0, 0, "R7");
        step(1, 1, 0, 1, 0, 0, "R7");
        step(1, 0, 0, 1, 0, 1, "R8");
        step(1, 1, 0, 1, 0, 1, "R7");
        step(1, 0, 1, 1, 0, 1, "R8");
        step(0, 0, 1, 1, 0, 1, "R8");
        step(0, 0, 1, 1, 0, 1, "R8");
        step(0, 0, 1, 1, 0, 1, "R8");
        step(0, 0, 0, 1, 0, 1, "R8");
        step(0, 0, 0, 1, 0, 1, "R8");
        step(0, 0, 0, 1, 0, 1, "R8");
        step(0, 1, 0, 1, 0, 1, "R7");
        step(0, 1, 0, 0, 1, 1, "R8");
        do_reset();
        step(0, 0, 0, 0, 0, 0, "R1");

        // request withdrawn during entry: R10
        step(1, 0, 0, 0, 0, 0, "R10");
        step(1, 0, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 1, 0, 0, "R10");
        step(0, 0, 0, 1, 0, 0, "R10");
        step(0, 0, 0, 1, 0, 0, "R10");
        step(0, 0, 1, 1, 0, 0, "R10");
        step(0, 0, 0, 1, 0, 0, "R10");
        step(0, 0, 0, 1, 0, 0, "R10");
        step(0, 0, 0, 1, 0, 0, "R10");
        step(0, 0, 0, 1, 0, 0, "R10");
        step(0, 1, 0, 0, 1, 0, "R10");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule